// File: doc/BRIEF.md
# Sticky Control Word with Atomic Set/Modify Aliases

This block holds one 64-bit control and status word behind a simple register request port. Software can reach the word through three neighbouring word offsets: a plain offset that reads and overwrites it, a modify alias, and a bit-set (OR) alias. The two aliases let several agents change individual bits without a separate read followed by a write, because each alias performs its read-modify-write inside the block in one clock cycle.

Only the top 16 bits of the word are stored; every lower bit is dropped on update and reads back as zero. The most significant stored bit drives a level interrupt output. A build-time parameter selects one of two layouts. Layout 0 places the word at word offset 0x4020 and its modify alias performs a bitwise AND. Layout 1 places it at word offset 0x6080 and its modify alias clears the word regardless of the data written.

Top module: `misc_reg_alias`

## Requirements
- R1: Only data bits 63..48 are stored; bits 47..0 of the word are discarded on every update and read back as 0.
- R2: `irq` equals stored bit 63 and changes on the same clock edge as the stored word after any update.
- R3: A write to the plain offset replaces the stored bits with wdata[63:48]; a read of the plain offset puts the stored word on `rd_data` one cycle after the request.
- R4: With VARIANT=0, word offset 0x4020 is plain, 0x4021 replaces the word with word AND wdata, 0x4022 replaces it with word OR wdata.
- R5: With VARIANT=1, word offset 0x6080 is plain, 0x6081 clears the word to 0 whatever the wdata, 0x6082 replaces it with word OR wdata.
- R6: A read of either alias offset or of any unmapped offset returns 0 on `rd_data`.
- R7: A write to an unmapped offset leaves the stored word unchanged.
- R8: Synchronous reset clears the stored word and `irq`.
- R9: The word offset is the byte address shifted right by three; address bits 2..0 do not affect decoding.
- R10: Any request (read or write) to an unmapped offset raises `bad_addr` for exactly the following cycle; a mapped request leaves it low.
- R11: `rd_data` is 0 in every cycle not following a plain-offset read.
- R12: Alias writes issued on consecutive cycles each take effect, each one building on the result of the previous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the 8-byte access |
| req_wdata | input | DATA_W | Write data, bit 63 most significant |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, copy of stored bit 63 |
| bad_addr | output | 1 | One-cycle pulse after an unmapped request |

## Verification
The bench builds two copies side by side, one with VARIANT=0 and one with VARIANT=1, both fed from the same request bus. Because each copy's three offsets are unmapped for the other, every write doubles as an unmapped-write test on the other copy, so the AND alias, the clear alias, the shared OR alias and the untouched-word case are all observed from a single stimulus stream, including addresses with nonzero low bits.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PLAIN  = 2'd1,
    OP_MODIFY = 2'd2,
    OP_OR     = 2'd3
  } misc_op_e;

  // Word offset of the plain register for each layout.
  function automatic logic [31:0] plain_word_off(input int variant);
    return (variant == 0) ? 32'h0000_4020 : 32'h0000_6080;
  endfunction

endpackage

// File: rtl/misc_addr_decode.sv
module misc_addr_decode
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output misc_op_e          op
);

  localparam int WORD_W = ADDR_W - 3;
  localparam logic [31:0] BASE32 = plain_word_off(VARIANT);
  localparam logic [WORD_W-1:0] BASE_OFF = WORD_W'(BASE32);
  localparam logic [WORD_W-1:0] MOD_OFF  = WORD_W'(BASE32 + 32'd1);
  localparam logic [WORD_W-1:0] OR_OFF   = WORD_W'(BASE32 + 32'd2);

  logic [WORD_W-1:0] word_off;
  logic              unused_lsb;

  assign word_off   = addr[ADDR_W-1:3];
  assign unused_lsb = ^addr[2:0];

  always_comb begin
    if (word_off == BASE_OFF)     op = OP_PLAIN;
    else if (word_off == MOD_OFF) op = OP_MODIFY;
    else if (word_off == OR_OFF)  op = OP_OR;
    else                          op = OP_NONE;
  end

endmodule

// File: rtl/misc_reg_core.sv
module misc_reg_core
  import misc_reg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IMPL_W  = 16,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  misc_op_e          op,
  input  logic [DATA_W-1:0] wdata,
  output logic [IMPL_W-1:0] field_q,
  output logic              irq
);

  localparam int LO_W = DATA_W - IMPL_W;

  logic [IMPL_W-1:0] hi_w;
  logic [IMPL_W-1:0] mod_val;
  logic [IMPL_W-1:0] nxt;
  logic              unused_lo;

  assign hi_w      = wdata[DATA_W-1:LO_W];
  assign unused_lo = ^wdata[LO_W-1:0];

  generate
    if (VARIANT == 0) begin : g_and
      assign mod_val = field_q & hi_w;
    end else begin : g_clear
      assign mod_val = '0;
    end
  endgenerate

  always_comb begin
    case (op)
      OP_PLAIN:  nxt = hi_w;
      OP_MODIFY: nxt = mod_val;
      OP_OR:     nxt = field_q | hi_w;
      default:   nxt = field_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
      irq     <= 1'b0;
    end else if (upd_en) begin
      field_q <= nxt;
      irq     <= nxt[IMPL_W-1];
    end
  end

  // R2: a plain write sets irq from the written top bit on the next edge
  assert_irq_plain_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_PLAIN) |=> irq == $past(wdata[DATA_W-1]));

  // R4/R5: the OR alias never clears a bit that was set
  assert_or_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_OR) |=> ((field_q & $past(field_q)) == $past(field_q)));

  generate
    if (VARIANT == 0) begin : g_chk_and
      // R4: the AND alias never sets a bit that was clear
      assert_and_no_set_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op == OP_MODIFY) |=> ((field_q & ~$past(field_q)) == '0));
    end else begin : g_chk_clr
      // R5: the clear alias empties the word
      assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op == OP_MODIFY) |=> (field_q == '0 && !irq));
    end
  endgenerate

endmodule

// File: rtl/misc_read_port.sv
module misc_read_port
  import misc_reg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMPL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  misc_op_e          op,
  input  logic [IMPL_W-1:0] field_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_addr
);

  localparam int LO_W = DATA_W - IMPL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      bad_addr <= 1'b0;
    end else begin
      rd_data  <= (valid && !write && op == OP_PLAIN) ? {field_q, {LO_W{1'b0}}} : '0;
      bad_addr <= valid && (op == OP_NONE);
    end
  end

  // R1: the unstored low bits never appear on the read port
  assert_low_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rd_data[LO_W-1:0] == '0);

  // R10: an unmapped request is flagged on the following cycle
  assert_bad_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_NONE) |=> bad_addr);

  // R6: alias and unmapped reads return zero
  assert_alias_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !write && op != OP_PLAIN) |=> rd_data == '0);

endmodule

// File: rtl/misc_reg_alias.sv
module misc_reg_alias
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int IMPL_W  = 16,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              bad_addr
);

  misc_op_e          op;
  logic              upd_en;
  logic [IMPL_W-1:0] field_q;

  assign upd_en = req_valid && req_write && (op != OP_NONE);

  misc_addr_decode #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_dec (
    .addr (req_addr),
    .op   (op)
  );

  misc_reg_core #(.DATA_W(DATA_W), .IMPL_W(IMPL_W), .VARIANT(VARIANT)) u_core (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .op      (op),
    .wdata   (req_wdata),
    .field_q (field_q),
    .irq     (irq)
  );

  misc_read_port #(.DATA_W(DATA_W), .IMPL_W(IMPL_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .valid    (req_valid),
    .write    (req_write),
    .op       (op),
    .field_q  (field_q),
    .rd_data  (rd_data),
    .bad_addr (bad_addr)
  );

  // R7: an unmapped write leaves the word alone
  assert_unmapped_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && op == OP_NONE) |=> $stable(field_q));

  // R2: irq follows the stored top bit after every mapped write
  assert_irq_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> irq == field_q[IMPL_W-1]);

endmodule

// File: tb/test_misc_reg_alias.sv
module test_misc_reg_alias;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NVEC   = 12;

  // {byte address, write data, expected top16 of layout 0, expected top16 of layout 1}
  localparam logic [127:0] VEC [NVEC] = '{
    {32'h0002_0100, 64'hF0F0_1234_5678_9ABC, 16'hF0F0, 16'h0000},
    {32'h0003_0400, 64'h8001_FFFF_0000_0000, 16'hF0F0, 16'h8001},
    {32'h0002_0108, 64'h3C3C_FFFF_FFFF_FFFF, 16'h3030, 16'h8001},
    {32'h0002_0110, 64'h8000_0000_0000_0001, 16'hB030, 16'h8001},
    {32'h0003_0410, 64'h0F00_0000_0000_0000, 16'hB030, 16'h8F01},
    {32'h0003_0408, 64'hFFFF_FFFF_FFFF_FFFF, 16'hB030, 16'h0000},
    {32'h0003_0410, 64'h4000_0000_0000_0000, 16'hB030, 16'h4000},
    {32'h0002_0108, 64'h7FFF_FFFF_FFFF_FFFF, 16'h3030, 16'h4000},
    {32'h0002_0118, 64'hFFFF_FFFF_FFFF_FFFF, 16'h3030, 16'h4000},
    {32'h0002_0117, 64'h0004_0000_0000_0000, 16'h3034, 16'h4000},
    {32'h0003_0405, 64'h1234_0000_0000_0000, 16'h3034, 16'h1234},
    {32'h0003_0418, 64'hFFFF_FFFF_FFFF_FFFF, 16'h3034, 16'h1234}
  };

  localparam logic [ADDR_W-1:0] A_PLAIN = 32'h0002_0100;
  localparam logic [ADDR_W-1:0] A_MOD   = 32'h0002_0108;
  localparam logic [ADDR_W-1:0] A_OR    = 32'h0002_0110;
  localparam logic [ADDR_W-1:0] B_PLAIN = 32'h0003_0400;
  localparam logic [ADDR_W-1:0] NOMAP   = 32'h0002_0118;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              irq_a, irq_b, bad_a, bad_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  misc_reg_alias #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_W(16), .VARIANT(0)) i_misc_reg_alias (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_a), .irq(irq_a), .bad_addr(bad_a)
  );

  misc_reg_alias #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_W(16), .VARIANT(1)) i_misc_reg_alias_b (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_b), .irq(irq_b), .bad_addr(bad_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request; returns at the negedge where its results are visible.
  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  function automatic bit mapped(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] w;
    w = a >> 3;
    return (w >= (base >> 3)) && (w <= (base >> 3) + 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 irq_a in reset", {63'd0, irq_a}, 64'd0);
    chk("R8 irq_b in reset", {63'd0, irq_b}, 64'd0);
    rst = 1'b0;
    access(1'b0, A_PLAIN, '0);
    chk("R8 R3 reset value A", rd_a, 64'd0);
    access(1'b0, B_PLAIN, '0);
    chk("R8 R3 reset value B", rd_b, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic [15:0] ea, eb;
      {a, d, ea, eb} = VEC[i];
      access(1'b1, a, d);
      chk($sformatf("R2 irq_a vec %0d", i), {63'd0, irq_a}, {63'd0, ea[15]});
      chk($sformatf("R2 irq_b vec %0d", i), {63'd0, irq_b}, {63'd0, eb[15]});
      chk($sformatf("R10 bad_a vec %0d", i), {63'd0, bad_a}, {63'd0, !mapped(a, A_PLAIN)});
      chk($sformatf("R10 bad_b vec %0d", i), {63'd0, bad_b}, {63'd0, !mapped(a, B_PLAIN)});
      chk($sformatf("R11 rd_a after write %0d", i), rd_a, 64'd0);
      access(1'b0, A_PLAIN, '0);
      chk($sformatf("R4 R7 R9 R1 word A vec %0d", i), rd_a, {ea, 48'd0});
      access(1'b0, B_PLAIN, '0);
      chk($sformatf("R5 R7 R9 R1 word B vec %0d", i), rd_b, {eb, 48'd0});
    end

    // R6: alias reads return zero, mapped so no flag
    access(1'b0, A_MOD, '0);
    chk("R6 read AND alias", rd_a, 64'd0);
    chk("R10 mapped alias read no flag", {63'd0, bad_a}, 64'd0);
    access(1'b0, A_OR, '0);
    chk("R6 read OR alias", rd_a, 64'd0);
    access(1'b0, NOMAP, '0);
    chk("R6 read unmapped", rd_a, 64'd0);
    chk("R10 unmapped read flag", {63'd0, bad_a}, 64'd1);
    @(negedge clk);
    chk("R10 flag lasts one cycle", {63'd0, bad_a}, 64'd0);
    chk("R11 idle rd_a", rd_a, 64'd0);

    // R12: back-to-back alias writes on consecutive cycles
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_PLAIN; req_wdata = 64'hFF00_0000_0000_0000;
    @(negedge clk);
    req_addr = A_OR;  req_wdata = 64'h00FF_0000_0000_0000;
    @(negedge clk);
    req_addr = A_MOD; req_wdata = 64'h0FF0_FFFF_FFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    access(1'b0, A_PLAIN, '0);
    chk("R12 back-to-back result A", rd_a, 64'h0FF0_0000_0000_0000);
    chk("R2 irq_a clear after AND", {63'd0, irq_a}, 64'd0);
    access(1'b0, B_PLAIN, '0);
    chk("R7 B untouched by A burst", rd_b, 64'h1234_0000_0000_0000);

    // R8: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, A_PLAIN, '0);
    chk("R8 mid-run reset A", rd_a, 64'd0);
    access(1'b0, B_PLAIN, '0);
    chk("R8 mid-run reset B", rd_b, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule